// File: doc/BRIEF.md
# Three-Wire Radio Register Serial Master

This block is the host-side master for the three-wire serial control port of a radio front-end. A single start strobe launches one transaction. The transaction is either a register write, which sends a 12-bit value to a 4-bit register address, or a register read, which sends a 5-bit address and returns a 12-bit value. The block drives four pins: an enable line, a serial clock, a read/write line and a data line. The data line is split into an output value, an output enable and an input, so the tristate buffer can sit at the pad.

Every phase of a transaction lasts a whole number of ticks. A parameterised clock divider produces the ticks, and one tick is the basic hold time of the serial bus. A write sends two data bits per serial clock pulse. A read first sends its address in the same way. It then turns the bus around: the read/write line goes high, the data output is released, and the radio drives the line. The master collects 12 bits, one per stretched clock-high interval. While a transaction is in progress the block shows busy, and a one-cycle done pulse marks its end.

Top module: `rf3w_master`

## Requirements
- R1: A write sends a 16-bit frame most significant bit first. Bits 15..4 of the frame are the write data and bits 3..0 are the low four address bits.
- R2: In idle the enable line is low. A transaction holds it high for PRE_TICKS ticks, then low for GAP_TICKS ticks and for all serial bits, then high again for POST_TICKS ticks, and then low in idle. The serial clock is always low while enable is high.
- R3: A write uses eight serial clock pulses. An even-numbered frame bit is valid on the rising edge, and the following odd-numbered bit replaces it while the clock is high and is valid on the falling edge.
- R4: A read first sends the 5 address bits most significant bit first, with the same edge pattern as a write. The read/write line stays low during these bits.
- R5: In a read, the read/write line rises while the serial clock is high, after the edge that carries the last address bit. It stays high until the closing enable-high phase ends. In a write it never goes high.
- R6: The data output enable is low only during the read data phase. That phase lasts (12*(1+HIGH_TICKS)+1)*DIV cycles and contains exactly 12 rising serial clock edges. The output enable is high again when enable rises at the end.
- R7: Each read bit is sampled from the data input on the last system clock of a clock-high interval that lasts HIGH_TICKS ticks. The bits arrive most significant first, and rd_data presents the assembled 12-bit value.
- R8: busy stays high for exactly (PRE+GAP+32+POST)*DIV cycles for a write and (PRE+GAP+10+2+12*(1+HIGH)+1+POST)*DIV cycles for a read.
- R9: busy rises in the cycle after the start strobe. done is high for exactly one cycle, the first cycle in which busy is low again. rd_data keeps the last read value through any later write.
- R10: A start strobe that arrives while busy is high has no effect on the running transaction: its frame, its timing and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transaction |
| rd_wr | input | 1 | 1 = register read, 0 = register write |
| addr | input | RD_ADDR_W | Register address (writes use the low WR_ADDR_W bits) |
| wdata | input | DATA_W | Value to write |
| rd_data | output | DATA_W | Value returned by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rf_en | output | 1 | Serial enable line |
| rf_sclk | output | 1 | Serial clock line |
| rf_rw | output | 1 | Read/write direction line |
| rf_sdo | output | 1 | Data line output value |
| rf_sdoe | output | 1 | Data line output enable |
| rf_sdi | input | 1 | Data line input value |

## Verification
The hardest case to reach from the ports is the sampling instant of a read bit. A master that samples a little too early in the clock-high interval returns correct data whenever the radio holds the line steady. To expose this, the bench models the radio so that it drives the inverse of each bit for most of the high interval and the true bit only in its final system clock. A second situation that is awkward to provoke is a start strobe landing in the middle of a read. The bench raises one with a different address and direction, then checks that the pin-level frame, the busy length and the returned data match an undisturbed read.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;

   // Sequencer phases; the order has no meaning outside the sequencer.
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,    // enable high before the frame
      ST_GAP,    // enable low, clock low, before the first bit
      ST_SHIFT,  // two ticks per bit, two bits per clock pulse
      ST_TURN,   // read only: direction line raised, clock falls
      ST_RLOW,   // read data: clock low, data released
      ST_RHIGH,  // read data: stretched clock high, sample at end
      ST_TAIL,   // read data: final clock-low tick
      ST_POST    // enable high after the frame
   } phase_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rf3w_tick.sv
module rf3w_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("rf3w_tick: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt <= '0;
            else if (!run)                cnt <= '0;
            else if (cnt == CW'(DIV - 1)) cnt <= '0;
            else                          cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == CW'(DIV - 1));

         // R8: ticks never come in back-to-back cycles when DIV > 1
         p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/rf3w_shreg.sv
module rf3w_shreg #(
   parameter int FRAME_W = 16,
   parameter int DATA_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_val,
   input  logic               shift_tx,
   input  logic               cap,
   input  logic               sdi,
   output logic               tx_bit,
   output logic [DATA_W-1:0]  rx_data
);

   logic [FRAME_W-1:0] tx_sr;
   logic [DATA_W-1:0]  rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_sr <= '0;
      else if (load)     tx_sr <= load_val;
      else if (shift_tx) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rx_sr <= '0;
      else if (cap) rx_sr <= {rx_sr[DATA_W-2:0], sdi};
   end

   assign tx_bit  = tx_sr[FRAME_W-1];
   assign rx_data = rx_sr;

   // R9: the read value only moves on a capture strobe
   p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(rx_sr));

endmodule

// File: rtl/rf3w_seq.sv
module rf3w_seq
   import rf3w_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int WR_ADDR_W  = 4,
   parameter int RD_ADDR_W  = 5,
   parameter int PRE_TICKS  = 2,
   parameter int GAP_TICKS  = 2,
   parameter int POST_TICKS = 2,
   parameter int HIGH_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rd_wr,
   input  logic tick,
   input  logic tx_bit,
   output logic run,
   output logic busy,
   output logic done,
   output logic load,
   output logic shift_tx,
   output logic cap,
   output logic rf_en,
   output logic rf_sclk,
   output logic rf_rw,
   output logic rf_sdo,
   output logic rf_sdoe
);

   localparam int FRAME_W = DATA_W + WR_ADDR_W;
   localparam int CNT_MAX = max_of(max_of(PRE_TICKS, GAP_TICKS),
                                   max_of(max_of(POST_TICKS, HIGH_TICKS), 2));
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam int BW      = $clog2(max_of(FRAME_W, DATA_W) + 1);

   phase_e          st;
   logic            is_rd;
   logic [CW-1:0]   cnt;
   logic [CW-1:0]   plen_m1;
   logic [BW-1:0]   bidx;
   logic [BW-1:0]   nbits_m1;
   logic            last;

   always_comb begin
      case (st)
         ST_PRE:   plen_m1 = CW'(PRE_TICKS - 1);
         ST_GAP:   plen_m1 = CW'(GAP_TICKS - 1);
         ST_SHIFT: plen_m1 = CW'(1);
         ST_TURN:  plen_m1 = CW'(1);
         ST_RHIGH: plen_m1 = CW'(HIGH_TICKS - 1);
         ST_POST:  plen_m1 = CW'(POST_TICKS - 1);
         default:  plen_m1 = '0;
      endcase
   end

   assign nbits_m1 = is_rd ? BW'(RD_ADDR_W - 1) : BW'(FRAME_W - 1);
   assign last     = tick && (cnt == plen_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         is_rd <= 1'b0;
         cnt   <= '0;
         bidx  <= '0;
         done  <= 1'b0;
      end else begin
         done <= (st == ST_POST) && last;
         if (st == ST_IDLE) begin
            if (start) begin
               st    <= ST_PRE;
               is_rd <= rd_wr;
               cnt   <= '0;
               bidx  <= '0;
            end
         end else if (tick) begin
            if (!last) begin
               cnt <= cnt + 1'b1;
            end else begin
               cnt <= '0;
               case (st)
                  ST_PRE:   st <= ST_GAP;
                  ST_GAP:   st <= ST_SHIFT;
                  ST_SHIFT: begin
                     if (bidx == nbits_m1) begin
                        bidx <= '0;
                        st   <= is_rd ? ST_TURN : ST_POST;
                     end else begin
                        bidx <= bidx + 1'b1;
                     end
                  end
                  ST_TURN:  st <= ST_RLOW;
                  ST_RLOW:  st <= ST_RHIGH;
                  ST_RHIGH: begin
                     if (bidx == BW'(DATA_W - 1)) begin
                        bidx <= '0;
                        st   <= ST_TAIL;
                     end else begin
                        bidx <= bidx + 1'b1;
                        st   <= ST_RLOW;
                     end
                  end
                  ST_TAIL:  st <= ST_POST;
                  default:  st <= ST_IDLE;
               endcase
            end
         end
      end
   end

   // control strobes to the divider and shift registers
   assign busy     = (st != ST_IDLE);
   assign run      = busy;
   assign load     = (st == ST_IDLE) && start;
   assign shift_tx = (st == ST_SHIFT) && last && (bidx != nbits_m1);
   assign cap      = (st == ST_RHIGH) && last;

   // pin decode: even bits rise mid-bit, odd bits fall mid-bit
   always_comb begin
      case (st)
         ST_SHIFT: rf_sclk = bidx[0] ^ cnt[0];
         ST_TURN:  rf_sclk = ~cnt[0];
         ST_RHIGH: rf_sclk = 1'b1;
         default:  rf_sclk = 1'b0;
      endcase
   end

   assign rf_en   = (st == ST_PRE) || (st == ST_POST);
   assign rf_rw   = (st inside {ST_TURN, ST_RLOW, ST_RHIGH, ST_TAIL}) ||
                    ((st == ST_POST) && is_rd);
   assign rf_sdoe = !(st inside {ST_RLOW, ST_RHIGH, ST_TAIL});
   assign rf_sdo  = tx_bit && (st inside {ST_GAP, ST_SHIFT, ST_TURN, ST_POST});

   // R2: serial clock held low whenever enable is high
   p_clk_low_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rf_en |-> !rf_sclk);

   // R5: direction line rises only while the clock is high
   p_rw_rise_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_rw) |-> rf_sclk);

   // R6: data released only with the direction line high
   p_release_rw_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_sdoe |-> rf_rw);

   // R9: done lasts one cycle and follows the end of busy
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R10: a strobe during a transaction leaves its direction alone
   p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(is_rd));

endmodule

// File: rtl/rf3w_master.sv
module rf3w_master #(
   parameter int DIV        = 4,
   parameter int DATA_W     = 12,
   parameter int WR_ADDR_W  = 4,
   parameter int RD_ADDR_W  = 5,
   parameter int PRE_TICKS  = 2,
   parameter int GAP_TICKS  = 2,
   parameter int POST_TICKS = 2,
   parameter int HIGH_TICKS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 rd_wr,
   input  logic [RD_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 busy,
   output logic                 done,
   output logic                 rf_en,
   output logic                 rf_sclk,
   output logic                 rf_rw,
   output logic                 rf_sdo,
   output logic                 rf_sdoe,
   input  logic                 rf_sdi
);

   localparam int FRAME_W = DATA_W + WR_ADDR_W;

   generate
      if (FRAME_W % 2 != 0) begin : g_bad_frame
         $error("rf3w_master: write frame must hold an even bit count");
      end
      if (RD_ADDR_W % 2 != 1) begin : g_bad_rd_addr
         $error("rf3w_master: read address must hold an odd bit count");
      end
      if (RD_ADDR_W > FRAME_W || WR_ADDR_W > RD_ADDR_W) begin : g_bad_addr
         $error("rf3w_master: address widths do not fit the frame");
      end
      if (PRE_TICKS < 1 || GAP_TICKS < 1 || POST_TICKS < 1 || HIGH_TICKS < 1)
      begin : g_bad_ticks
         $error("rf3w_master: every phase needs at least one tick");
      end
   endgenerate

   logic               tick, run, load, shift_tx, cap, tx_bit;
   logic [FRAME_W-1:0] load_val;

   // read frames put the address at the top; writes put data above address
   assign load_val = rd_wr ? {addr, {(FRAME_W - RD_ADDR_W){1'b0}}}
                           : {wdata, addr[WR_ADDR_W-1:0]};

   rf3w_tick #(.DIV(DIV)) i_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   rf3w_seq #(
      .DATA_W    (DATA_W),
      .WR_ADDR_W (WR_ADDR_W),
      .RD_ADDR_W (RD_ADDR_W),
      .PRE_TICKS (PRE_TICKS),
      .GAP_TICKS (GAP_TICKS),
      .POST_TICKS(POST_TICKS),
      .HIGH_TICKS(HIGH_TICKS)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .rd_wr   (rd_wr),
      .tick    (tick),
      .tx_bit  (tx_bit),
      .run     (run),
      .busy    (busy),
      .done    (done),
      .load    (load),
      .shift_tx(shift_tx),
      .cap     (cap),
      .rf_en   (rf_en),
      .rf_sclk (rf_sclk),
      .rf_rw   (rf_rw),
      .rf_sdo  (rf_sdo),
      .rf_sdoe (rf_sdoe)
   );

   rf3w_shreg #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) i_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .load_val(load_val),
      .shift_tx(shift_tx),
      .cap     (cap),
      .sdi     (rf_sdi),
      .tx_bit  (tx_bit),
      .rx_data (rd_data)
   );

endmodule

// File: tb/test_rf3w_master.sv
module test_rf3w_master;

   localparam int CLK_PERIOD = 10;
   localparam int DIV  = 4;
   localparam int PRE  = 2;
   localparam int GAP  = 2;
   localparam int POST = 2;
   localparam int HIGH = 3;
   localparam int WR_CYC  = (PRE + GAP + 32 + POST) * DIV;
   localparam int RD_CYC  = (PRE + GAP + 10 + 2 + 12 * (1 + HIGH) + 1 + POST) * DIV;
   localparam int OE_LOW  = (12 * (1 + HIGH) + 1) * DIV;
   localparam int EN_CYC  = (PRE + POST) * DIV;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd_wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [11:0] wdata = '0;
   logic [11:0] rd_data;
   logic        busy, done, rf_en, rf_sclk, rf_rw, rf_sdo, rf_sdoe;
   logic        rf_sdi = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rf3w_master #(
      .DIV(DIV), .PRE_TICKS(PRE), .GAP_TICKS(GAP),
      .POST_TICKS(POST), .HIGH_TICKS(HIGH)
   ) i_rf3w_master (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr), .addr(addr),
      .wdata(wdata), .rd_data(rd_data), .busy(busy), .done(done),
      .rf_en(rf_en), .rf_sclk(rf_sclk), .rf_rw(rf_rw), .rf_sdo(rf_sdo),
      .rf_sdoe(rf_sdoe), .rf_sdi(rf_sdi)
   );

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] resp_of(input int a);
      return 12'((a * 709 + 2362) ^ (a << 7));
   endfunction

   // pin monitor and radio model
   int          nb, busy_cyc, en_cyc, oe_low_cyc, rel_rise, rise_cnt;
   int          rw_in_wr, rw_rise_low, en_clk_bad, k, cd;
   logic [15:0] frm;
   logic        post_rw, post_oe, cur_rd;
   logic [11:0] cur_resp;
   logic        p_sclk = 1'b0, p_rw = 1'b0, p_en = 1'b0, p_oe = 1'b1;

   always @(negedge clk) begin
      if (busy) busy_cyc++;
      if (rf_en) en_cyc++;
      if (!rf_sdoe) oe_low_cyc++;
      if (rf_en && rf_sclk) en_clk_bad++;
      if (rf_rw && !cur_rd) rw_in_wr++;
      if (rf_rw && !p_rw && !rf_sclk) rw_rise_low++;
      if (rf_sclk && !p_sclk) rise_cnt++;
      if (rf_en && !p_en) begin
         post_rw = rf_rw;
         post_oe = rf_sdoe;
      end
      if ((rf_sclk != p_sclk) && rf_sdoe && !rf_rw && busy) begin
         frm = {frm[14:0], rf_sdo};
         nb++;
      end
      if (!rf_sdoe && p_oe) k = 0;
      if (!rf_sdoe && rf_sclk && !p_sclk) begin
         rel_rise++;
         rf_sdi = (k < 12) ? ~cur_resp[11 - k] : 1'b0;
         cd = HIGH * DIV - 1;
      end else if (cd > 0) begin
         cd--;
         if (cd == 0 && k < 12) rf_sdi = cur_resp[11 - k];
      end
      if (!rf_sdoe && !rf_sclk && p_sclk) k++;
      p_sclk = rf_sclk;
      p_rw   = rf_rw;
      p_en   = rf_en;
      p_oe   = rf_sdoe;
   end

   task automatic txn(input bit rd, input int a, input int d, input int strobe_at);
      logic [11:0] prev;
      int n;
      @(negedge clk);
      prev = rd_data;
      nb = 0; busy_cyc = 0; en_cyc = 0; oe_low_cyc = 0; rel_rise = 0; rise_cnt = 0;
      rw_in_wr = 0; rw_rise_low = 0; en_clk_bad = 0; k = 0; cd = 0; frm = '0;
      post_rw = 1'b0; post_oe = 1'b0;
      cur_rd = rd; cur_resp = resp_of(a);
      start = 1'b1; rd_wr = rd; addr = 5'(a); wdata = 12'(d);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after strobe", int'(busy), 1);
      n = 0;
      while (!done) begin
         @(negedge clk);
         n++;
         if (strobe_at != 0 && n == strobe_at) begin
            start = 1'b1; rd_wr = ~rd; addr = 5'(a ^ 11); wdata = ~12'(d);
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
      chk(busy_cyc == (rd ? RD_CYC : WR_CYC), "R8 busy length", busy_cyc,
          rd ? RD_CYC : WR_CYC);
      chk(en_cyc == EN_CYC, "R2 enable high cycles", en_cyc, EN_CYC);
      chk(en_clk_bad == 0, "R2 clock high under enable", en_clk_bad, 0);
      if (!rd) begin
         chk(nb == 16 && frm == {12'(d), 4'(a)}, "R1 write frame", int'(frm),
             int'({12'(d), 4'(a)}));
         chk(rise_cnt == 8, "R3 write clock pulses", rise_cnt, 8);
         chk(rw_in_wr == 0, "R5 rw low in write", rw_in_wr, 0);
         chk(oe_low_cyc == 0, "R6 no release in write", oe_low_cyc, 0);
         chk(rd_data == prev, "R9 read value kept over write", int'(rd_data), int'(prev));
      end else begin
         chk(nb == 5 && frm[4:0] == 5'(a), "R4 read address", int'(frm[4:0]), a);
         chk(rise_cnt == 15, "R4 read clock pulses", rise_cnt, 15);
         chk(rw_rise_low == 0 && post_rw == 1'b1, "R5 rw turnaround", int'(post_rw), 1);
         chk(oe_low_cyc == OE_LOW && rel_rise == 12 && post_oe == 1'b1,
             "R6 data release", oe_low_cyc, OE_LOW);
         chk(rd_data == resp_of(a), "R7 read data", int'(rd_data), int'(resp_of(a)));
      end
      @(negedge clk);
      chk(!done && !busy && !rf_en && !rf_rw && rf_sdoe, "R9 done one cycle then idle",
          int'({done, busy, rf_en, rf_rw}), 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         tests++;
         $display("FAIL R8 watchdog act=%0d exp=<150000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !rf_en && !rf_sclk && !rf_rw && rf_sdoe && rd_data == 12'h0,
          "R2 reset state", int'({busy, done, rf_en, rf_sclk, rf_rw, rf_sdoe}), 1);

      for (int a = 0; a < 16; a++) begin
         txn(1'b0, a, 0, 0);
         txn(1'b0, a, 12'hFFF, 0);
         txn(1'b0, a, 12'hA5A ^ a, 0);
         txn(1'b0, a, a * 12'h111, 0);
      end
      for (int a = 0; a < 32; a++) begin
         txn(1'b1, a, 0, 0);
         txn(1'b0, 31 - a, a * 37, 0);   // R9 write keeps the read value
      end
      // R10 strobes while busy, early, mid-address and mid-data
      txn(1'b1, 19, 0, 3);
      txn(1'b1, 6, 0, 40);
      txn(1'b1, 27, 0, 150);
      txn(1'b0, 9, 12'h3C7, 60);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule